// File: doc/BRIEF.md
# Low-Speed Packet Line Transmitter

This block sends one packet on a low-speed two-wire differential serial bus. A controller first writes the packet body into a small byte buffer through a simple write port. It then pulses a start request with a byte count. The block sends a fixed synchronisation byte, followed by the buffered bytes. Each byte goes out least significant bit first. The line uses NRZI coding with bit stuffing, and every bit lasts a fixed number of clocks.

A second request kind sends a handshake packet. This packet carries only the synchronisation byte and one packet-identifier byte, which is taken from an input instead of the buffer. The block frames every packet in the same way. It places idle J on the wires before it enables the drivers, and it closes the packet with single-ended zero and then J. After that it releases the drivers with both wires low.

A pending device address is copied into the active address when the bus is released after a data packet. The copy never happens after a handshake. A busy flag and a one-cycle done pulse let the controller sequence its requests.

Top module: `nrzi_tx`

## Requirements
- R1: After reset, `oe_o`, `dp_o`, `dm_o`, `busy_o` and `done_o` are 0, and `dev_addr_o` is 0.
- R2: A start request that is sampled while idle sets `busy_o` at the same edge and drives J (`dp_o`=0, `dm_o`=1) with `oe_o`=0 for one cycle. The next cycle keeps J with `oe_o`=1. The first bit appears one cycle after that.
- R3: The block first sends the synchronisation byte 0x80 and then the packet bytes. Each byte goes out LSB first and each bit is held for `BIT_CLKS` clocks (12). A 0 bit toggles the line between J and K (K is `dp_o`=1, `dm_o`=0). A 1 bit leaves the line unchanged.
- R4: After six consecutive transmitted 1 bits, one extra toggle bit is inserted and the run count restarts. Runs are counted across byte boundaries, and a stuff bit is also inserted after the final data bit when that bit completes a run of six.
- R5: With `kind_i`=0, `len_i` is the packet length including the synchronisation byte. The bytes after sync are buffer entries 0 to `len_i`-2. A `len_i` below 2 is treated as 2, and a value above `MAX_LEN` (12) is treated as `MAX_LEN`.
- R6: With `kind_i`=1, the packet is the synchronisation byte followed by `pid_i`, which is sampled with the start request. The buffer is not read.
- R7: After the last bit (or stuff bit), both wires are driven low with `oe_o`=1 for two bit times, then J for one bit time. At the next edge, `oe_o`, `dp_o` and `dm_o` become 0, `busy_o` falls and `done_o` is high for exactly one cycle.
- R8: At the release edge of a data packet, `dev_addr_o` takes the value of `pend_addr_i`. After a handshake packet, `dev_addr_o` is unchanged.
- R9: A start request that arrives while `busy_o` is high is ignored. The packet in progress keeps its timing and content, and no second packet follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to send one packet |
| kind_i | input | 1 | 0 = data packet from buffer, 1 = handshake packet |
| len_i | input | 4 | Data packet length in bytes, sync included |
| pid_i | input | 8 | Identifier byte for a handshake packet |
| buf_we_i | input | 1 | Buffer write enable |
| buf_waddr_i | input | 4 | Buffer write address |
| buf_wdata_i | input | 8 | Buffer write data |
| pend_addr_i | input | 7 | Device address to commit after a data packet |
| dp_o | output | 1 | Positive line level |
| dm_o | output | 1 | Negative line level |
| oe_o | output | 1 | Line driver enable |
| busy_o | output | 1 | Transmission in progress |
| done_o | output | 1 | One-cycle pulse after bus release |
| dev_addr_o | output | 7 | Active device address |

## Verification
Packets are chosen so that the line model tells apart several kinds of stuffing. A body of all zeros never stuffs. A run that starts in the sync byte stuffs early. A run that crosses a byte boundary stuffs in the second byte. A run that ends on the final bit needs a trailing stuff bit before end of packet. A maximum-length body of all ones stuffs fourteen times. Handshake packets check that the buffer is bypassed and that the address is not committed. Lengths below and above the legal range check clamping, and a start pulse in the middle of a packet checks that a busy block ignores it.

// File: rtl/nrzi_tx_pkg.sv
package nrzi_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRESET,
    ST_BITS,
    ST_SE0,
    ST_EOPJ
  } tx_state_e;

  localparam logic [7:0] SYNC_BYTE = 8'h80;
  localparam int         STUFF_RUN = 6;
  localparam int         SE0_SLOTS = 2;
endpackage

// File: rtl/nrzi_txbuf.sv
module nrzi_txbuf #(
  parameter int DEPTH = 11,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i && (int'(waddr_i) < DEPTH)) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (int'(raddr_i) < DEPTH) rdata_o <= mem[raddr_i];
    else                       rdata_o <= '0;
  end
endmodule

// File: rtl/nrzi_bit_timer.sv
module nrzi_bit_timer #(
  parameter int BIT_CLKS = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  input  logic prime_i,
  output logic tick_o
);
  localparam int CW = (BIT_CLKS > 1) ? $clog2(BIT_CLKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(BIT_CLKS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (prime_i)   cnt <= LAST;
    else if (run_i)     cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    else                cnt <= '0;
  end

  assign tick_o = run_i && (cnt == LAST);

  // R3: bit slots are spaced a full bit period apart
  a_r3_tick_spacing: assert property (@(posedge clk) disable iff (rst)
    (tick_o && run_i && (BIT_CLKS > 1)) |=> !tick_o);
endmodule

// File: rtl/nrzi_tx_core.sv
module nrzi_tx_core
  import nrzi_tx_pkg::*;
#(
  parameter int MAX_LEN = 12,
  parameter int AW      = 4,
  parameter int LEN_W   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             kind_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [7:0]       pid_i,
  input  logic [7:0]       rd_q_i,
  input  logic             tick_i,
  output logic [AW-1:0]    rd_addr_o,
  output logic             run_o,
  output logic             prime_o,
  output logic             dp_o,
  output logic             dm_o,
  output logic             oe_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             commit_o
);
  tx_state_e        state;
  logic [7:0]       shreg;
  logic [3:0]       bits_left;
  logic [LEN_W-1:0] bytes_left;
  logic [2:0]       ones;
  logic             hs_q;
  logic [7:0]       pid_q;
  logic             slot_n;
  logic [LEN_W-1:0] len_eff;
  logic [7:0]       next_byte;
  logic             stuff_now;

  always_comb begin
    if (len_i < LEN_W'(2))            len_eff = LEN_W'(2);
    else if (len_i > LEN_W'(MAX_LEN)) len_eff = LEN_W'(MAX_LEN);
    else                              len_eff = len_i;
  end

  assign next_byte = hs_q ? pid_q : rd_q_i;
  assign stuff_now = (ones == 3'(STUFF_RUN));
  assign run_o     = (state == ST_BITS) || (state == ST_SE0) || (state == ST_EOPJ);
  assign prime_o   = (state == ST_PRESET);
  assign commit_o  = (state == ST_EOPJ) && tick_i && !hs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      shreg      <= '0;
      bits_left  <= '0;
      bytes_left <= '0;
      ones       <= '0;
      hs_q       <= 1'b0;
      pid_q      <= '0;
      slot_n     <= 1'b0;
      rd_addr_o  <= '0;
      dp_o       <= 1'b0;
      dm_o       <= 1'b0;
      oe_o       <= 1'b0;
      busy_o     <= 1'b0;
      done_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start_i) begin
            state      <= ST_PRESET;
            busy_o     <= 1'b1;
            dp_o       <= 1'b0;
            dm_o       <= 1'b1;
            oe_o       <= 1'b0;
            shreg      <= SYNC_BYTE;
            bits_left  <= 4'd8;
            bytes_left <= kind_i ? LEN_W'(1) : len_eff - LEN_W'(1);
            ones       <= '0;
            hs_q       <= kind_i;
            pid_q      <= pid_i;
            rd_addr_o  <= '0;
          end
        end
        ST_PRESET: begin
          state <= ST_BITS;
          oe_o  <= 1'b1;
        end
        ST_BITS: begin
          if (tick_i) begin
            if (stuff_now) begin
              dp_o <= ~dp_o;
              dm_o <= ~dm_o;
              ones <= '0;
            end else if (bits_left != 4'd0) begin
              if (shreg[0]) begin
                ones <= ones + 3'd1;
              end else begin
                dp_o <= ~dp_o;
                dm_o <= ~dm_o;
                ones <= '0;
              end
              if ((bits_left == 4'd1) && (bytes_left != '0)) begin
                shreg      <= next_byte;
                bits_left  <= 4'd8;
                bytes_left <= bytes_left - LEN_W'(1);
                if (!hs_q) rd_addr_o <= rd_addr_o + 1'b1;
              end else begin
                shreg     <= {1'b0, shreg[7:1]};
                bits_left <= bits_left - 4'd1;
              end
            end else begin
              state  <= ST_SE0;
              dp_o   <= 1'b0;
              dm_o   <= 1'b0;
              slot_n <= 1'b0;
            end
          end
        end
        ST_SE0: begin
          if (tick_i) begin
            if (slot_n == 1'(SE0_SLOTS - 1)) begin
              state <= ST_EOPJ;
              dm_o  <= 1'b1;
            end else begin
              slot_n <= 1'b1;
            end
          end
        end
        ST_EOPJ: begin
          if (tick_i) begin
            state  <= ST_IDLE;
            oe_o   <= 1'b0;
            dp_o   <= 1'b0;
            dm_o   <= 1'b0;
            busy_o <= 1'b0;
            done_o <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: drivers are enabled only onto an idle J level
  a_r2_j_before_enable: assert property (@(posedge clk) disable iff (rst)
    $rose(oe_o) |-> $past(!dp_o && dm_o));

  // R3: the line only moves at a bit slot
  a_r3_hold_between_slots: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BITS && !tick_i) |=> $stable({dp_o, dm_o}));

  // R3: during the bit phase the line is always a differential J or K
  a_r3_differential: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BITS) |-> (dp_o != dm_o));

  // R4: a full run of ones forces a toggle in the next slot
  a_r4_stuff_toggle: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BITS && tick_i && stuff_now) |=> (dp_o != $past(dp_o)));

  // R7: end of packet holds both wires low while driven
  a_r7_se0_level: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SE0) |-> (!dp_o && !dm_o && oe_o));

  // R7: release leaves both wires low, clears busy and pulses done
  a_r7_release: assert property (@(posedge clk) disable iff (rst)
    $fell(oe_o) |-> (done_o && !busy_o && !dp_o && !dm_o));

  // R9: drivers are never on outside a busy window
  a_r9_oe_inside_busy: assert property (@(posedge clk) disable iff (rst)
    oe_o |-> busy_o);

  // R9: a packet in progress is never restarted
  a_r9_no_restart: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |=> (state != ST_PRESET));
endmodule

// File: rtl/nrzi_tx.sv
module nrzi_tx #(
  parameter int BIT_CLKS = 12,
  parameter int MAX_LEN  = 12,
  parameter int ADDR_W   = 7,
  localparam int BUF_DEPTH = MAX_LEN - 1,
  localparam int AW        = $clog2(BUF_DEPTH),
  localparam int LEN_W     = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              kind_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [7:0]        pid_i,
  input  logic              buf_we_i,
  input  logic [AW-1:0]     buf_waddr_i,
  input  logic [7:0]        buf_wdata_i,
  input  logic [ADDR_W-1:0] pend_addr_i,
  output logic              dp_o,
  output logic              dm_o,
  output logic              oe_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] dev_addr_o
);
  logic [AW-1:0] rd_addr;
  logic [7:0]    rd_q;
  logic          tick;
  logic          run;
  logic          prime;
  logic          commit;

  nrzi_txbuf #(.DEPTH(BUF_DEPTH), .AW(AW)) u_buf (
    .clk     (clk),
    .we_i    (buf_we_i),
    .waddr_i (buf_waddr_i),
    .wdata_i (buf_wdata_i),
    .raddr_i (rd_addr),
    .rdata_o (rd_q)
  );

  nrzi_bit_timer #(.BIT_CLKS(BIT_CLKS)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .run_i   (run),
    .prime_i (prime),
    .tick_o  (tick)
  );

  nrzi_tx_core #(.MAX_LEN(MAX_LEN), .AW(AW), .LEN_W(LEN_W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .kind_i    (kind_i),
    .len_i     (len_i),
    .pid_i     (pid_i),
    .rd_q_i    (rd_q),
    .tick_i    (tick),
    .rd_addr_o (rd_addr),
    .run_o     (run),
    .prime_o   (prime),
    .dp_o      (dp_o),
    .dm_o      (dm_o),
    .oe_o      (oe_o),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .commit_o  (commit)
  );

  always_ff @(posedge clk) begin
    if (rst)         dev_addr_o <= '0;
    else if (commit) dev_addr_o <= pend_addr_i;
  end

  // R8: the active address changes only at the release of a data packet
  a_r8_commit_on_data_release: assert property (@(posedge clk) disable iff (rst)
    !$stable(dev_addr_o) |-> ($past(commit) && done_o));
endmodule

// File: tb/sim_nrzi_tx.sv
module sim_nrzi_tx;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic       kind_i = 1'b0;
  logic [3:0] len_i = 4'd0;
  logic [7:0] pid_i = 8'h00;
  logic       buf_we_i = 1'b0;
  logic [3:0] buf_waddr_i = 4'd0;
  logic [7:0] buf_wdata_i = 8'h00;
  logic [6:0] pend_addr_i = 7'd0;
  logic       dp_o, dm_o, oe_o, busy_o, done_o;
  logic [6:0] dev_addr_o;

  int nchk = 0;
  int nfail = 0;
  logic [6:0] exp_addr = 7'd0;

  always #5 clk = ~clk;

  nrzi_tx u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .kind_i(kind_i), .len_i(len_i),
    .pid_i(pid_i), .buf_we_i(buf_we_i), .buf_waddr_i(buf_waddr_i),
    .buf_wdata_i(buf_wdata_i), .pend_addr_i(pend_addr_i), .dp_o(dp_o),
    .dm_o(dm_o), .oe_o(oe_o), .busy_o(busy_o), .done_o(done_o),
    .dev_addr_o(dev_addr_o)
  );

  // stimulus and expected slot count (bits + stuff bits) per packet
  localparam int NV = 7;
  localparam logic       V_KIND  [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
  localparam logic [3:0] V_LEN   [NV] = '{4'd2, 4'd2, 4'd3, 4'd3, 4'd2, 4'd2, 4'd12};
  localparam logic [87:0] V_BYTES [NV] = '{88'hFF, 88'h0, 88'hFC3F, 88'h07E0,
                                           88'h00, 88'h0, {11{8'hFF}}};
  localparam logic [7:0] V_PID   [NV] = '{8'h00, 8'hD2, 8'h00, 8'h00, 8'h00, 8'h5A, 8'h00};
  localparam int         V_SLOTS [NV] = '{17, 16, 26, 25, 16, 16, 110};

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_buf(input logic [87:0] bytes);
    for (int k = 0; k < 11; k++) begin
      @(negedge clk);
      buf_we_i    = 1'b1;
      buf_waddr_i = 4'(k);
      buf_wdata_i = bytes[8*k +: 8];
    end
    @(negedge clk);
    buf_we_i = 1'b0;
  endtask

  task automatic run_pkt(input logic kind, input logic [3:0] len, input logic [87:0] bytes,
                         input logic [7:0] pid, input logic [6:0] pend, input int exp_n,
                         input bit inject, input string tag);
    logic [7:0] seq [12];
    logic       lvl [128];
    int nb, n, ones, le, rel, mism;
    logic cur;
    seq[0] = 8'h80;
    if (kind) begin
      nb = 2;
      seq[1] = pid;
    end else begin
      le = (len < 2) ? 2 : ((len > 12) ? 12 : int'(len));
      nb = le;
      for (int k = 1; k < nb; k++) seq[k] = bytes[8*(k-1) +: 8];
    end
    cur = 1'b1; ones = 0; n = 0;
    for (int k = 0; k < nb; k++) begin
      for (int b = 0; b < 8; b++) begin
        if (seq[k][b]) ones++;
        else begin cur = ~cur; ones = 0; end
        lvl[n] = cur; n++;
        if (ones == 6) begin cur = ~cur; ones = 0; lvl[n] = cur; n++; end
      end
    end
    chk({tag, " R4 slot count"}, n, exp_n);
    if (!kind) load_buf(bytes);
    pend_addr_i = pend;
    @(negedge clk);
    start_i = 1'b1; kind_i = kind; len_i = len; pid_i = pid;
    @(negedge clk);
    start_i = 1'b0;
    chk("R2 busy at start", int'(busy_o), 1);
    chk("R2 preset J oe low", int'({oe_o, dp_o, dm_o}), 3'b001);
    rel = 2 + 12 * (exp_n + 3);
    mism = 0;
    for (int i = 1; i <= rel + 1; i++) begin
      @(negedge clk);
      if (inject && i == 40) begin start_i = 1'b1; kind_i = 1'b1; len_i = 4'd2; end
      if (inject && i == 41) start_i = 1'b0;
      if (i == 1) chk("R2 enabled on J", int'({oe_o, dp_o, dm_o}), 3'b101);
      if (i >= 2 && i < 2 + 12 * exp_n && ((i - 2) % 12) == 6) begin
        if ({dp_o, dm_o} != (lvl[(i - 2) / 12] ? 2'b01 : 2'b10) || !oe_o) mism++;
      end
      if (i == 2 + 12 * exp_n + 6 || i == 2 + 12 * exp_n + 18)
        chk("R7 SE0", int'({oe_o, dp_o, dm_o}), 3'b100);
      if (i == 2 + 12 * (exp_n + 2) + 6) chk("R7 EOP J", int'({oe_o, dp_o, dm_o}), 3'b101);
      if (i == rel - 1) chk("R7 still driven", int'({busy_o, oe_o}), 2'b11);
      if (i == rel) begin
        chk("R7 released", int'({oe_o, dp_o, dm_o, busy_o, done_o}), 5'b00001);
        if (!kind) exp_addr = pend;
        chk("R8 device address", int'(dev_addr_o), int'(exp_addr));
      end
      if (i == rel + 1) chk("R7 done one cycle", int'(done_o), 0);
    end
    chk({tag, " R3 line levels"}, mism, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset outputs", int'({oe_o, dp_o, dm_o, busy_o, done_o}), 0);
    chk("R1 reset address", int'(dev_addr_o), 0);

    for (int v = 0; v < NV; v++)
      run_pkt(V_KIND[v], V_LEN[v], V_BYTES[v], V_PID[v], 7'(7'h10 + v), V_SLOTS[v], 1'b0,
              V_KIND[v] ? "R6 handshake" : "R5 data");

    // R5: lengths below and above range are clamped
    run_pkt(1'b0, 4'd1, 88'h0, 8'h00, 7'h2A, 16, 1'b0, "R5 clamp low");
    run_pkt(1'b0, 4'd15, {11{8'hFF}}, 8'h00, 7'h2B, 110, 1'b0, "R5 clamp high");

    // R9: a start pulse mid-packet changes nothing
    run_pkt(1'b0, 4'd3, 88'h07E0, 8'h00, 7'h33, 25, 1'b1, "R9 busy ignore");
    repeat (30) @(negedge clk);
    chk("R9 no second packet", int'({busy_o, oe_o}), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule